// File: doc/BRIEF.md
# Power-Rail Fault Supervisor

This block is the digital fault manager of a multi-rail power controller. It receives comparator results as boolean flags: rail-1 overvoltage, rail-1 overcurrent, and undervoltage on rails 2, 3 and 4. It also receives two soft-start "ramp complete" flags and one "ramp node discharged" flag. From these it decides whether to shut the chip down for good or to run a hiccup retry. It drives an inhibit for rails 1 to 3, a request to discharge the soft-start node, a permanent-latch output and a state code.

Overvoltage and rail-4 undervoltage are hard faults. Rail-1 overcurrent and rail-2/3 undervoltage are retry faults, each counted on its own saturating counter. The third strike on either counter locks the chip off. Undervoltage is masked until the matching ramp is complete. A retry waits for the discharged flag, then starts a new ramp. A clean start-up clears both counters. Only the power-on reset (`rst_ni`) leaves the locked-off state.

Top module: `rail_fault_supervisor`

## Requirements
- R1: A rail-1 overvoltage seen in state 0, 1 or 3 moves the block to state 4 (locked off), with `inhibit_o` and `latched_o` high. The overvoltage flag is never masked.
- R2: A rail-4 undervoltage seen in state 0, 1 or 3 while `ss24_up_i` is high moves the block to state 4. Neither counter changes.
- R3: A rail-1 overcurrent seen in state 0, 1 or 3 adds one to `oc_count_o` and moves the block to state 2 (retry discharge). State 2 drives `inhibit_o` and `ss_discharge_o` high.
- R4: A rail-2 or rail-3 undervoltage seen in state 0, 1 or 3 while `ss13_up_i` is high adds one to `uv_count_o` and moves the block to state 2.
- R5: The fault that brings either counter to 3 moves the block to state 4 instead of state 2. The counters saturate at 3.
- R6: `uv2_i` and `uv3_i` are ignored while `ss13_up_i` is low. `uv4_i` is ignored while `ss24_up_i` is low.
- R7: State 2 holds until `ss24_low_i` is high. The block then enters state 3 (retry ramp), where `inhibit_o` and `ss_discharge_o` are low.
- R8: In state 0 or 3, both up flags high with no fault flag high moves the block to state 1 (running) and clears both counters.
- R9: State 4 ignores all inputs and keeps `inhibit_o` high. Reset is the only exit. Reset gives state 0, both counts 0, and all control outputs low.
- R10: Every flag input passes a two-flop synchronizer. A change that is driven between clock edges reaches the outputs after the third rising edge.
- R11: Fault flags are ignored in state 2, so a fault held high is counted once per retry cycle.
- R12: State codes on `state_o`: 0 start-up, 1 running, 2 retry discharge, 3 retry ramp, 4 locked off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ov1_i | input | 1 | Rail-1 overvoltage flag |
| oc1_i | input | 1 | Rail-1 overcurrent flag |
| uv2_i | input | 1 | Rail-2 undervoltage flag |
| uv3_i | input | 1 | Rail-3 undervoltage flag |
| uv4_i | input | 1 | Rail-4 undervoltage flag |
| ss13_up_i | input | 1 | Rails 1/3 ramp complete |
| ss24_up_i | input | 1 | Rails 2/4 ramp complete |
| ss24_low_i | input | 1 | Rails 2/4 soft-start node discharged |
| inhibit_o | output | 1 | Inhibit rails 1 to 3 |
| ss_discharge_o | output | 1 | Discharge request for the soft-start node |
| latched_o | output | 1 | Permanent shutdown latch |
| state_o | output | 3 | State code (R12) |
| oc_count_o | output | 2 | Overcurrent strike count |
| uv_count_o | output | 2 | Rail-2/3 undervoltage strike count |

## Verification
The assertions run on every cycle and cover four invariants: the lock-off is sticky and always inhibits, the retry-discharge state drives both inhibit and discharge, the counters do not move during discharge, and the running state never carries a non-zero count. Other behaviours need a stimulus sequence, so only the bench scenarios show them. These are the three-strike escalation, the masking of undervoltage before ramp completion, the counter clear on a clean start-up, and the three-edge latency. The bench reference model also checks hard-fault priority over counting on every cycle.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_RUN   = 3'd1,
    ST_DIS   = 3'd2,
    ST_RAMP  = 3'd3,
    ST_LOCK  = 3'd4
  } rfs_state_e;

  // flag vector bit positions
  localparam int unsigned F_OV1  = 0;
  localparam int unsigned F_OC1  = 1;
  localparam int unsigned F_UV2  = 2;
  localparam int unsigned F_UV3  = 3;
  localparam int unsigned F_UV4  = 4;
  localparam int unsigned F_UP13 = 5;
  localparam int unsigned F_UP24 = 6;
  localparam int unsigned F_LOW  = 7;
  localparam int unsigned NFLAGS = 8;
endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rfs_strike_ctr.sv
module rfs_strike_ctr #(
  parameter int unsigned MAX_STRIKES = 3,
  localparam int unsigned CW = $clog2(MAX_STRIKES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] count_o,
  output logic          lockout_o
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_STRIKES);

  logic [CW-1:0] cnt_q;

  // lockout flags the strike that will reach the limit
  assign lockout_o = inc_i && (cnt_q == LIMIT - CW'(1));
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
  import rfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] flags_i,
  input  logic              oc_lock_i,
  input  logic              uv_lock_i,
  output logic              oc_inc_o,
  output logic              uv_inc_o,
  output logic              clr_o,
  output rfs_state_e        state_o
);
  rfs_state_e st_q, st_d;
  logic active, hard, oc_ev, uv_ev, any_fault, success;

  // faults are acted on only outside discharge and lock-off
  assign active    = (st_q == ST_START) || (st_q == ST_RUN) || (st_q == ST_RAMP);
  assign any_fault = |flags_i[F_UV4:F_OV1];
  assign hard      = active && (flags_i[F_OV1] || (flags_i[F_UV4] && flags_i[F_UP24]));
  assign oc_ev     = active && !hard && flags_i[F_OC1];
  assign uv_ev     = active && !hard && flags_i[F_UP13] && (flags_i[F_UV2] || flags_i[F_UV3]);
  assign success   = ((st_q == ST_START) || (st_q == ST_RAMP)) &&
                     flags_i[F_UP13] && flags_i[F_UP24] && !any_fault;

  assign oc_inc_o = oc_ev;
  assign uv_inc_o = uv_ev;
  assign clr_o    = success;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_START, ST_RUN, ST_RAMP: begin
        if (hard || (oc_ev && oc_lock_i) || (uv_ev && uv_lock_i)) st_d = ST_LOCK;
        else if (oc_ev || uv_ev)                                   st_d = ST_DIS;
        else if (success)                                          st_d = ST_RUN;
      end
      ST_DIS:  if (flags_i[F_LOW]) st_d = ST_RAMP;
      ST_LOCK: st_d = ST_LOCK;
      default: st_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_START;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
  import rfs_pkg::*;
#(
  parameter int unsigned MAX_STRIKES = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_STRIKES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ov1_i,
  input  logic          oc1_i,
  input  logic          uv2_i,
  input  logic          uv3_i,
  input  logic          uv4_i,
  input  logic          ss13_up_i,
  input  logic          ss24_up_i,
  input  logic          ss24_low_i,
  output logic          inhibit_o,
  output logic          ss_discharge_o,
  output logic          latched_o,
  output logic [2:0]    state_o,
  output logic [CW-1:0] oc_count_o,
  output logic [CW-1:0] uv_count_o
);
  logic [NFLAGS-1:0] raw, flags;
  logic oc_inc, uv_inc, clr, oc_lock, uv_lock;
  rfs_state_e st;

  always_comb begin
    raw         = '0;
    raw[F_OV1]  = ov1_i;
    raw[F_OC1]  = oc1_i;
    raw[F_UV2]  = uv2_i;
    raw[F_UV3]  = uv3_i;
    raw[F_UV4]  = uv4_i;
    raw[F_UP13] = ss13_up_i;
    raw[F_UP24] = ss24_up_i;
    raw[F_LOW]  = ss24_low_i;
  end

  rfs_sync #(.W(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(flags)
  );

  rfs_strike_ctr #(.MAX_STRIKES(MAX_STRIKES)) u_oc_ctr (
    .clk_i, .rst_ni, .inc_i(oc_inc), .clr_i(clr),
    .count_o(oc_count_o), .lockout_o(oc_lock)
  );

  rfs_strike_ctr #(.MAX_STRIKES(MAX_STRIKES)) u_uv_ctr (
    .clk_i, .rst_ni, .inc_i(uv_inc), .clr_i(clr),
    .count_o(uv_count_o), .lockout_o(uv_lock)
  );

  rfs_fsm u_fsm (
    .clk_i, .rst_ni, .flags_i(flags),
    .oc_lock_i(oc_lock), .uv_lock_i(uv_lock),
    .oc_inc_o(oc_inc), .uv_inc_o(uv_inc), .clr_o(clr),
    .state_o(st)
  );

  assign state_o        = st;
  assign inhibit_o      = (st == ST_DIS) || (st == ST_LOCK);
  assign ss_discharge_o = (st == ST_DIS);
  assign latched_o      = (st == ST_LOCK);
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inhibit_o,
  input logic          ss_discharge_o,
  input logic          latched_o,
  input logic [2:0]    state_o,
  input logic [CW-1:0] oc_count_o,
  input logic [CW-1:0] uv_count_o
);
  localparam logic [CW-1:0] TOP = '1;

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |=> latched_o && state_o == 3'd4);

  a_r1_lock_inhibits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> inhibit_o);

  a_r3_discharge_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |-> inhibit_o && ss_discharge_o);

  a_r11_no_count_in_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |=> $stable(oc_count_o) && $stable(uv_count_o));

  a_r8_run_counts_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 |-> oc_count_o == '0 && uv_count_o == '0);

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_count_o == TOP |=> oc_count_o == TOP);

  a_r12_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);
endmodule

bind rail_fault_supervisor rfs_checker #(.CW(CW)) u_rfs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inhibit_o(inhibit_o),
  .ss_discharge_o(ss_discharge_o), .latched_o(latched_o), .state_o(state_o),
  .oc_count_o(oc_count_o), .uv_count_o(uv_count_o)
);

// File: tb/rail_fault_supervisor_test.sv
module rail_fault_supervisor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ov1 = 0, oc1 = 0, uv2 = 0, uv3 = 0, uv4 = 0, up13 = 0, up24 = 0, low = 0;
  logic inh, dis, lat;
  logic [2:0] st;
  logic [1:0] occ, uvc;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .ov1_i(ov1), .oc1_i(oc1), .uv2_i(uv2),
    .uv3_i(uv3), .uv4_i(uv4), .ss13_up_i(up13), .ss24_up_i(up24),
    .ss24_low_i(low), .inhibit_o(inh), .ss_discharge_o(dis), .latched_o(lat),
    .state_o(st), .oc_count_o(occ), .uv_count_o(uvc)
  );

  // reference model: inputs seen two edges late, then one state update
  bit [7:0] hist[$];
  int m_st, m_oc, m_uv;

  function automatic bit [7:0] cur_in();
    return {low, up24, up13, uv4, uv3, uv2, oc1, ov1};
  endfunction

  task automatic model_step(bit [7:0] v);
    bit act, hrd, oe, ue, ok;
    act = (m_st == 0 || m_st == 1 || m_st == 3);
    hrd = act && (v[0] || (v[4] && v[6]));
    oe  = act && !hrd && v[1];
    ue  = act && !hrd && v[5] && (v[2] || v[3]);
    ok  = (m_st == 0 || m_st == 3) && v[5] && v[6] && (v[4:0] == 0);
    if (m_st == 2) begin
      if (v[7]) m_st = 3;
    end else if (act) begin
      if (oe) m_oc = (m_oc < 3) ? m_oc + 1 : 3;
      if (ue) m_uv = (m_uv < 3) ? m_uv + 1 : 3;
      if (hrd || (oe && m_oc == 3) || (ue && m_uv == 3)) m_st = 4;
      else if (oe || ue) m_st = 2;
      else if (ok) begin m_st = 1; m_oc = 0; m_uv = 0; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_oc = 0; m_uv = 0;
      hist = '{8'h00, 8'h00};
    end else begin
      bit [7:0] v;
      v = hist.pop_front();
      hist.push_back(cur_in());
      model_step(v);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R12 model state", st, m_st);
    chk("R3 model oc count", occ, m_oc);
    chk("R4 model uv count", uvc, m_uv);
    chk("R9 model inhibit", inh, (m_st == 2 || m_st == 4));
    chk("R7 model discharge", dis, (m_st == 2));
    chk("R1 model latched", lat, (m_st == 4));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_in();
    ov1 = 0; oc1 = 0; uv2 = 0; uv3 = 0; uv4 = 0; up13 = 0; up24 = 0; low = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R9 reset state", st, 0);
    chk("R9 reset oc", occ, 0);
    chk("R9 reset inhibit", inh, 0);

    // masking before ramp completion
    uv2 = 1; uv3 = 1; uv4 = 1; cyc(5);
    chk("R6 masked uv state", st, 0);
    chk("R6 masked uv count", uvc, 0);
    uv2 = 0; uv3 = 0; uv4 = 0; cyc(3);

    // synchronizer latency
    up13 = 1; up24 = 1; cyc(2);
    chk("R10 no change after two edges", st, 0);
    cyc(1);
    chk("R10 change after third edge", st, 1);
    chk("R8 running", st, 1);

    // overcurrent retries to lockout
    oc1 = 1; cyc(4);
    chk("R3 oc discharge state", st, 2);
    chk("R3 oc count", occ, 1);
    chk("R3 discharge out", dis, 1);
    cyc(4);
    chk("R11 held fault counted once", occ, 1);
    oc1 = 0; up13 = 0; up24 = 0; cyc(4);
    chk("R7 waits for low", st, 2);
    low = 1; cyc(4);
    chk("R7 ramp state", st, 3);
    chk("R7 inhibit released", inh, 0);
    low = 0; oc1 = 1; cyc(4);
    chk("R3 second strike", occ, 2);
    oc1 = 0; low = 1; cyc(4); low = 0; oc1 = 1; cyc(4);
    chk("R5 third strike locks", st, 4);
    chk("R5 count saturates", occ, 3);
    ov1 = 1; uv2 = 1; up13 = 1; up24 = 1; low = 1; cyc(6);
    chk("R9 lock ignores inputs", st, 4);
    chk("R9 lock inhibits", inh, 1);
    clear_in(); do_reset();
    chk("R9 reset clears lock", lat, 0);

    // undervoltage retry and clean restart
    up13 = 1; up24 = 1; cyc(4);
    uv3 = 1; cyc(4);
    chk("R4 uv discharge state", st, 2);
    chk("R4 uv count", uvc, 1);
    uv3 = 0; low = 1; cyc(5); low = 0;
    chk("R8 restart runs", st, 1);
    chk("R8 counters cleared", uvc, 0);

    // rail-4 undervoltage is a hard fault
    uv4 = 1; cyc(4);
    chk("R2 uv4 locks", st, 4);
    chk("R2 no count", uvc, 0);
    clear_in(); do_reset();

    // overvoltage
    up13 = 1; up24 = 1; cyc(4);
    ov1 = 1; cyc(4);
    chk("R1 ov locks", st, 4);
    chk("R1 latched", lat, 1);
    clear_in(); cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule